// File: doc/BRIEF.md
# Prescaled Coefficient Dequantizer

This block dequantizes the coefficients of an 8x8 transform block with one multiply per coefficient, using a table whose entries already include the fixed per-position constants that an inverse transform would otherwise apply at its input. Those constant multiplies are folded into the quantization factors ahead of time, so the transform core that follows needs fewer multipliers.

Before a decode pass, the table is filled. A load phase accepts 64 raw quantization steps. Each step is multiplied by a per-position constant from an internal constant table, rounded, and written into the factor RAM. There is no global scale term, so each factor is just step times constant. The factors are computed once per load and are never recomputed while coefficients flow.

During decode, each coefficient arrives with either a natural (row-major) index or a zig-zag scan index. It leaves two cycles later, multiplied by the matching factor and saturated to a signed 20-bit result.

Top module: `scaled_dequant`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `tableReady` and `outValid` are 0.
- R2: The constant for natural position p (0..63) is unsigned Q1.14 with value 8192 + ((p*397) mod 8192). A step of 16384 therefore yields a factor equal to that constant.
- R3: A load beat writes factor = floor((step*constant + 8192) / 16384) for position `loadIdx`, clamped to 18 bits. A decoded coefficient leaves as coefficient times that factor.
- R4: `tableReady` rises on the cycle after the beat that completes writes to all 64 distinct positions. A repeated index counts once. Once high, `tableReady` stays high until `loadStart`.
- R5: `coefReady` equals `tableReady`. A `coefValid` beat while `coefReady` is 0 is stalled and produces no output.
- R6: `loadStart` clears all written marks and drops `tableReady` on the next cycle. It takes priority over a load beat in the same cycle. A load beat while `tableReady` is 1 leaves the table unchanged.
- R7: A coefficient accepted at clock edge k appears with `outValid` high after edge k+1. One coefficient is accepted per cycle, and outputs come out in order.
- R8: With `coefZz`=1, `coefIdx` is a zig-zag scan index. Index 0 maps to position 0, 1 to 1 (row 0, col 1), 2 to 8, 3 to 16, and so on along alternating anti-diagonals. `outPos` reports the natural position row*8+col in both modes.
- R9: Products above 524287 leave as 524287, and products below -524288 leave as -524288.
- R10: A zero coefficient leaves as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loadStart | input | 1 | Begins a new load phase |
| loadValid | input | 1 | Load beat strobe |
| loadIdx | input | 6 | Natural position of the step |
| loadStep | input | 16 | Raw quantization step |
| tableReady | output | 1 | All 64 factors written |
| coefValid | input | 1 | Coefficient strobe |
| coefReady | output | 1 | Coefficient can be accepted |
| coefIdx | input | 6 | Coefficient index |
| coefZz | input | 1 | 1: `coefIdx` is a zig-zag index |
| coefVal | input | 12 | Signed coefficient |
| outValid | output | 1 | Result strobe |
| outVal | output | 20 | Signed saturated result |
| outPos | output | 6 | Natural position of the result |

## Verification
The hardest cases to reach from the ports are saturation and the exact moment the table becomes ready. Saturation needs a large factor, so a second table is loaded with steps up to 65535 and then driven with coefficients near both ends of the 12-bit range. The readiness edge depends on counting distinct positions. The load order is therefore a permutation with repeated indices in it, and the ready flag is compared on every clock so that an early or late rise is visible. Load beats sent while the table is locked are followed by a decode of the same position, which shows at the output that the table did not change.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  typedef struct packed {
    logic tblWrite;  // write the prescaled factor for loadIdx
    logic coefTake;  // accept a coefficient into stage 1
    logic stage2;    // advance stage 1 into the output register
  } sdqStrobe_t;
endpackage

// File: rtl/sdq_ctrl.sv
module sdq_ctrl
  import sdq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadStart,
  input  logic             loadValid,
  input  logic [IDX_W-1:0] loadIdx,
  input  logic             coefValid,
  output logic             tableReady,
  output logic             coefReady,
  output logic             outValid,
  output sdqStrobe_t       strb
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] written;
  logic [ENTRIES-1:0] writtenNext;
  logic               stage1Valid;

  always_comb begin
    strb.tblWrite = loadValid && !tableReady && !loadStart;
    strb.coefTake = coefValid && tableReady;
    strb.stage2   = stage1Valid;
    writtenNext   = written;
    writtenNext[loadIdx] = 1'b1;
  end

  assign coefReady = tableReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      written     <= '0;
      tableReady  <= 1'b0;
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= strb.coefTake;
      outValid    <= stage1Valid;
      if (loadStart) begin
        written    <= '0;
        tableReady <= 1'b0;
      end else if (strb.tblWrite) begin
        written    <= writtenNext;
        tableReady <= &writtenNext;
      end
    end
  end
endmodule

// File: rtl/sdq_datapath.sv
module sdq_datapath
  import sdq_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int STEP_W  = 16,
  parameter int CONST_W = 15,
  parameter int FRAC    = 14,
  parameter int FACT_W  = 18,
  parameter int COEF_W  = 12,
  parameter int OUT_W   = 20
) (
  input  logic                     clk,
  input  sdqStrobe_t               strb,
  input  logic [IDX_W-1:0]         loadIdx,
  input  logic [STEP_W-1:0]        loadStep,
  input  logic [IDX_W-1:0]         coefIdx,
  input  logic                     coefZz,
  input  logic signed [COEF_W-1:0] coefVal,
  output logic signed [OUT_W-1:0]  outVal,
  output logic [IDX_W-1:0]         outPos
);
  localparam int ENTRIES  = 1 << IDX_W;
  localparam int SIDE     = 1 << (IDX_W / 2);
  localparam int RW       = STEP_W + CONST_W + 1;
  localparam int PW       = COEF_W + FACT_W + 1;
  localparam int FACT_MAX = (1 << FACT_W) - 1;
  localparam int OMAX     = (1 << (OUT_W - 1)) - 1;
  localparam int OMIN     = -(1 << (OUT_W - 1));
  localparam int HALF     = CONST_W - 1;

  // per-position Q1.14 constants, packed
  function automatic logic [ENTRIES*CONST_W-1:0] buildConst();
    logic [ENTRIES*CONST_W-1:0] v;
    v = '0;
    for (int p = 0; p < ENTRIES; p++)
      v[p*CONST_W +: CONST_W] = CONST_W'((1 << (HALF - 1)) + ((p * 397) % (1 << (HALF - 1))));
    return v;
  endfunction

  // zig-zag scan index -> natural position, walked along anti-diagonals
  function automatic logic [ENTRIES*IDX_W-1:0] buildZz();
    logic [ENTRIES*IDX_W-1:0] v;
    int k;
    v = '0;
    k = 0;
    for (int s = 0; s < 2 * SIDE - 1; s++) begin
      for (int j = 0; j < SIDE; j++) begin
        int r;
        r = (s % 2 == 1) ? ((s < SIDE ? 0 : s - SIDE + 1) + j)
                         : ((s < SIDE ? s : SIDE - 1) - j);
        if (r >= 0 && r < SIDE && (s - r) >= 0 && (s - r) < SIDE) begin
          v[k*IDX_W +: IDX_W] = IDX_W'(r * SIDE + (s - r));
          k++;
        end
      end
    end
    return v;
  endfunction

  localparam logic [ENTRIES*CONST_W-1:0] CONST_ROM = buildConst();
  localparam logic [ENTRIES*IDX_W-1:0]   ZZ_ROM    = buildZz();

  logic [FACT_W-1:0] factorTbl [ENTRIES];
  logic [RW-1:0]     rawProd;
  logic [RW-1:0]     rounded;
  logic [FACT_W-1:0] newFactor;
  logic [IDX_W-1:0]  natPos;

  logic signed [COEF_W-1:0] s1Coef;
  logic [FACT_W-1:0]        s1Fac;
  logic [IDX_W-1:0]         s1Pos;
  logic signed [PW-1:0]     prod;

  always_comb begin
    rawProd = RW'(loadStep) * RW'(CONST_ROM[loadIdx*CONST_W +: CONST_W])
            + RW'(1 << (FRAC - 1));
    rounded = rawProd >> FRAC;
    if (rounded > RW'(FACT_MAX)) newFactor = '1;
    else                         newFactor = rounded[FACT_W-1:0];
    natPos = coefZz ? ZZ_ROM[coefIdx*IDX_W +: IDX_W] : coefIdx;
    prod   = PW'(s1Coef) * PW'($signed({1'b0, s1Fac}));
  end

  always_ff @(posedge clk) begin
    if (strb.tblWrite) factorTbl[loadIdx] <= newFactor;
    if (strb.coefTake) begin
      s1Coef <= coefVal;
      s1Fac  <= factorTbl[natPos];
      s1Pos  <= natPos;
    end
    if (strb.stage2) begin
      outPos <= s1Pos;
      if (prod > PW'(OMAX))      outVal <= OUT_W'(OMAX);
      else if (prod < PW'(OMIN)) outVal <= OUT_W'(OMIN);
      else                       outVal <= prod[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/scaled_dequant.sv
module scaled_dequant
  import sdq_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int STEP_W  = 16,
  parameter int CONST_W = 15,
  parameter int FRAC    = 14,
  parameter int FACT_W  = 18,
  parameter int COEF_W  = 12,
  parameter int OUT_W   = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     loadStart,
  input  logic                     loadValid,
  input  logic [IDX_W-1:0]         loadIdx,
  input  logic [STEP_W-1:0]        loadStep,
  output logic                     tableReady,
  input  logic                     coefValid,
  output logic                     coefReady,
  input  logic [IDX_W-1:0]         coefIdx,
  input  logic                     coefZz,
  input  logic signed [COEF_W-1:0] coefVal,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outVal,
  output logic [IDX_W-1:0]         outPos
);
  sdqStrobe_t strb;

  sdq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .loadStart(loadStart), .loadValid(loadValid),
    .loadIdx(loadIdx), .coefValid(coefValid), .tableReady(tableReady),
    .coefReady(coefReady), .outValid(outValid), .strb(strb)
  );

  sdq_datapath #(
    .IDX_W(IDX_W), .STEP_W(STEP_W), .CONST_W(CONST_W), .FRAC(FRAC),
    .FACT_W(FACT_W), .COEF_W(COEF_W), .OUT_W(OUT_W)
  ) u_dp (
    .clk(clk), .strb(strb), .loadIdx(loadIdx), .loadStep(loadStep),
    .coefIdx(coefIdx), .coefZz(coefZz), .coefVal(coefVal),
    .outVal(outVal), .outPos(outPos)
  );
endmodule

// File: rtl/sdq_checker.sv
module sdq_checker #(
  parameter int COEF_W = 12,
  parameter int OUT_W  = 20
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     loadStart,
  input logic                     tableReady,
  input logic                     coefValid,
  input logic                     coefReady,
  input logic signed [COEF_W-1:0] coefVal,
  input logic                     outValid,
  input logic signed [OUT_W-1:0]  outVal
);
  p_start_clears_r6: assert property (@(posedge clk) disable iff (rst)
    loadStart |=> !tableReady);

  p_ready_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    tableReady && !loadStart |=> tableReady);

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    coefValid && coefReady |=> ##1 outValid);

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(coefValid && coefReady, 2));

  p_zero_passes_r10: assert property (@(posedge clk) disable iff (rst)
    outValid && $past(coefValid && coefReady && coefVal == '0, 2) |-> outVal == '0);
endmodule

bind scaled_dequant sdq_checker #(.COEF_W(COEF_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/scaled_dequant_bench.sv
module scaled_dequant_bench;
  logic clk = 0;
  logic rst = 1;
  logic loadStart = 0, loadValid = 0, coefValid = 0, coefZz = 0;
  logic [5:0] loadIdx = 0, coefIdx = 0;
  logic [15:0] loadStep = 0;
  logic signed [11:0] coefVal = 0;
  logic tableReady, coefReady, outValid;
  logic signed [19:0] outVal;
  logic [5:0] outPos;

  always #4 clk = ~clk;  // 125 MHz

  scaled_dequant u_scaled_dequant (.*);

  int checks = 0, fails = 0, cycles = 0;
  string curTag = "R3";

  // reference model
  int mTbl [64];
  bit [63:0] mWritten;
  bit mReady, v1, v2, e1zz;
  int e1coef, e1fac, e1pos, e2val, e2pos;
  string e2tag;
  int zzMap [64];

  function automatic int konst(int p);
    return 8192 + ((p * 397) % 8192);
  endfunction

  initial begin
    int r, c;
    bit up;
    r = 0; c = 0; up = 1;
    for (int k = 0; k < 64; k++) begin
      zzMap[k] = r * 8 + c;
      if (up) begin
        if (c == 7) begin r++; up = 0; end
        else if (r == 0) begin c++; up = 0; end
        else begin r--; c++; end
      end else begin
        if (r == 7) begin c++; up = 1; end
        else if (c == 0) begin r++; up = 1; end
        else begin r++; c--; end
      end
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      mWritten <= '0; mReady <= 0; v1 <= 0; v2 <= 0;
    end else begin
      longint p;
      string t;
      p = longint'(e1coef) * longint'(e1fac);
      if (e1coef == 0) t = "R10";
      else if (p > 524287 || p < -524288) t = "R9";
      else if (e1zz) t = "R8";
      else t = curTag;
      v2 <= v1;
      if (v1) begin
        e2val <= (p > 524287) ? 524287 : (p < -524288) ? -524288 : int'(p);
        e2pos <= e1pos;
        e2tag <= t;
      end
      v1 <= coefValid && mReady;
      if (coefValid && mReady) begin
        int pos;
        pos = coefZz ? zzMap[coefIdx] : int'(coefIdx);
        e1coef <= int'(coefVal);
        e1fac  <= mTbl[pos];
        e1pos  <= pos;
        e1zz   <= coefZz;
      end
      if (loadStart) begin
        mWritten <= '0; mReady <= 0;
      end else if (loadValid && !mReady) begin
        bit [63:0] w;
        longint f;
        f = (longint'(loadStep) * konst(loadIdx) + 8192) / 16384;
        mTbl[loadIdx] <= (f > 262143) ? 262143 : int'(f);
        w = mWritten; w[loadIdx] = 1;
        mWritten <= w;
        mReady <= &w;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst || cycles < 3) begin
      chk("R1", int'(tableReady), 0);
      chk("R1", int'(outValid), 0);
    end else begin
      chk("R4", int'(tableReady), int'(mReady));
      chk("R5", int'(coefReady), int'(mReady));
      chk("R7", int'(outValid), int'(v2));
      if (v2 && outValid) begin
        chk(e2tag, int'(outVal), e2val);
        chk("R8", int'(outPos), e2pos);
      end
    end
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic loadBeat(int idx, int step);
    loadValid = 1; loadIdx = 6'(idx); loadStep = 16'(step);
    tick();
    loadValid = 0;
  endtask

  task automatic coefBeat(int idx, bit zz, int v);
    coefValid = 1; coefIdx = 6'(idx); coefZz = zz; coefVal = 12'(v);
    tick();
    coefValid = 0;
  endtask

  initial begin
    int seed;
    seed = 12345;
    repeat (4) tick();
    rst = 0;
    repeat (2) tick();
    // R5: stalled requests before the table is ready
    coefValid = 1; coefVal = 12'sd7;
    repeat (5) tick();
    coefValid = 0;
    // R2/R4: unit steps, permuted order with repeats
    loadStart = 1; tick(); loadStart = 0;
    loadBeat(5, 16384); loadBeat(5, 16384);
    for (int k = 0; k < 64; k++) begin
      loadBeat((k * 37) % 64, 16384);
      if (k % 9 == 0) tick();
      if (k == 62) loadBeat(0, 16384);
    end
    repeat (2) tick();
    curTag = "R2";
    for (int k = 0; k < 64; k++) coefBeat(k, 0, 1);
    repeat (3) tick();
    // R8/R10: zig-zag and natural mixed
    curTag = "R3";
    for (int k = 0; k < 64; k++) coefBeat(k, k[0], ((k * 13) % 61) - 30);
    coefBeat(3, 1, 0);
    repeat (3) tick();
    // R6: loads while locked are ignored
    for (int k = 0; k < 4; k++) loadBeat(0, 0);
    curTag = "R6";
    coefBeat(0, 0, 5);
    coefBeat(1, 1, -3);
    repeat (3) tick();
    // R6: start of new pass, start beats load priority
    loadStart = 1; loadValid = 1; loadIdx = 6'd9; loadStep = 16'd1;
    tick();
    loadStart = 0; loadValid = 0;
    for (int k = 0; k < 64; k++) begin
      int st;
      st = (k * 40503 + 7) & 16'hFFFF;
      if (k == 10) st = 65535;
      if (k == 11) st = 0;
      if (k == 12) st = 1;
      loadBeat(k, st);
    end
    repeat (2) tick();
    // R9: extremes
    curTag = "R3";
    coefBeat(10, 0, 2047); coefBeat(10, 0, -2048);
    coefBeat(11, 0, 2047); coefBeat(12, 0, -2048);
    for (int k = 0; k < 300; k++) begin
      seed = seed * 1103515245 + 12345;
      if (seed[20]) begin
        coefValid = 1; coefIdx = seed[13:8]; coefZz = seed[5];
        coefVal = seed[30] ? 12'(seed[27:16]) : 12'(int'(seed[23:18]) - 32);
      end else coefValid = 0;
      tick();
    end
    coefValid = 0;
    repeat (5) tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule